// File: doc/BRIEF.md
# Dual-Mode Core-to-Host Transmit Path

This block moves data words from a processor core towards an external bus host. A mode register picks one of two behaviours. In fetch mode nothing is buffered ahead of the host. The core is asked for a word only while the host has a read transfer open. The path holds at most one word, and it is emptied as soon as the transfer closes. In pre-fetch mode the core fills a FIFO ahead of host reads. The depth is a parameter, and it halves when the wide word format is selected.

The block has two request flags. The core-side transmit request tells the core that it may write a word. The host-side receive request tells the host that a word is waiting. Each mode defines the transmit request differently. In fetch mode it means the host is reading and the path is empty. In pre-fetch mode it means the FIFO is below its capacity. Writing 1 to the mode register discards whatever the path holds.

Top module: `core_host_txpath`

## Requirements
- R1: After the synchronous active-high reset, the block is in fetch mode with an empty path. `coreTxReq` and `hostRxReq` are both 0 and `hostRdData` is 0.
- R2: A mode write of 1 (`modeWrEn`=1, `modeWrVal`=1) empties the path and switches to fetch mode. In the next cycle both `coreTxReq` and `hostRxReq` are 0.
- R3: In fetch mode, `coreTxReq` becomes 1 one cycle after `hostXferActive` is sampled high while the path is empty. A core write accepted in that state clears `coreTxReq` and sets `hostRxReq` in the next cycle.
- R4: In fetch mode the path holds at most one word. A core write while that word is present is ignored.
- R5: In fetch mode, any cycle with `hostXferActive`=0 discards the stored word and ignores core writes. After such a cycle both flags read 0.
- R6: In pre-fetch mode (a mode write of 0) the capacity is DEPTH words when `wideFmt` is 0 and DEPTH/2 words when it is 1. `coreTxReq` is 1 exactly while the stored word count is below the capacity.
- R7: `hostRxReq` is 1 exactly while the path holds a word. A `hostRdEn` strobe removes the oldest word, and that word appears on `hostRdData` one cycle later. Words leave in write order.
- R8: A `hostRdEn` strobe on an empty path leaves `hostRdData` at its last value and does not change the path state.
- R9: In pre-fetch mode a core write at capacity is ignored, even when a host read occurs in the same cycle.
- R10: A host read and a core write in the same cycle are both applied when the path is neither empty nor full. On an empty path only the write takes effect.
- R11: `wideFmt` is sampled only in cycles where the path is empty, or during reset. A change while words are stored does not alter the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeWrEn | input | 1 | Write strobe for the mode register |
| modeWrVal | input | 1 | Mode value: 1 fetch, 0 pre-fetch |
| wideFmt | input | 1 | Wide word format select; halves the pre-fetch depth |
| hostXferActive | input | 1 | Host has a read transfer open |
| coreWrEn | input | 1 | Core write strobe |
| coreWrData | input | DATA_W | Core write word |
| hostRdEn | input | 1 | Host read strobe, one word per cycle |
| hostRdData | output | DATA_W | Last word read by the host (registered) |
| coreTxReq | output | 1 | Core-side transmit request |
| hostRxReq | output | 1 | Host-side receive request |

## Verification
The bench builds the block with DATA_W=16 and DEPTH=6. At that depth both the full six-word FIFO and the three-word wide-format FIFO can be filled to capacity within a few cycles. Draining more than six words makes the ring pointers wrap. The same storage is also exercised in the one-word fetch mode, so that the flag behaviour at the empty and full edges can be compared across all three capacities.

// File: rtl/txpath_pkg.sv
package txpath_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } pathStrobes_t;
endpackage

// File: rtl/txpath_ctrl.sv
module txpath_ctrl
  import txpath_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeWrEn,
  input  logic             modeWrVal,
  input  logic             wideFmt,
  input  logic             hostXferActive,
  input  logic             coreWrEn,
  input  logic             hostRdEn,
  output pathStrobes_t     strobes,
  output logic             coreTxReq,
  output logic             hostRxReq,
  output logic [CNT_W-1:0] occupancy,
  output logic             fetchModeQ
);
  localparam int HALF = DEPTH / 2;

  logic             xferQ;
  logic             wideQ;
  logic [CNT_W-1:0] occQ;
  logic [CNT_W-1:0] curCap;
  logic             modeFlush;
  logic             idleFlush;

  always_comb begin
    modeFlush     = modeWrEn & modeWrVal;
    idleFlush     = fetchModeQ & ~hostXferActive;
    strobes.flush = modeFlush | idleFlush;
    if (fetchModeQ)  curCap = CNT_W'(1);
    else if (wideQ)  curCap = CNT_W'(HALF);
    else             curCap = CNT_W'(DEPTH);
    strobes.push = coreWrEn & (occQ < curCap) & ~strobes.flush;
    strobes.pop  = hostRdEn & (occQ != '0) & ~strobes.flush;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchModeQ <= 1'b1;
      xferQ      <= 1'b0;
      wideQ      <= wideFmt;
      occQ       <= '0;
    end else begin
      if (modeWrEn) fetchModeQ <= modeWrVal;
      xferQ <= hostXferActive & ~modeFlush;
      if (occQ == '0) wideQ <= wideFmt;
      if (strobes.flush) occQ <= '0;
      else begin
        case ({strobes.push, strobes.pop})
          2'b10:   occQ <= occQ + CNT_W'(1);
          2'b01:   occQ <= occQ - CNT_W'(1);
          default: occQ <= occQ;
        endcase
      end
    end
  end

  assign occupancy = occQ;
  assign hostRxReq = (occQ != '0);
  assign coreTxReq = fetchModeQ ? (xferQ & (occQ == '0)) : (occQ < curCap);
endmodule

// File: rtl/txpath_data.sv
module txpath_data
  import txpath_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  pathStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop) begin
        rdData <= store[rdPtr];
        rdPtr  <= nextPtr(rdPtr);
      end
    end
  end
endmodule

// File: rtl/core_host_txpath.sv
module core_host_txpath
  import txpath_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeWrEn,
  input  logic              modeWrVal,
  input  logic              wideFmt,
  input  logic              hostXferActive,
  input  logic              coreWrEn,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  output logic              coreTxReq,
  output logic              hostRxReq
);
  pathStrobes_t     strobes;
  logic [CNT_W-1:0] occupancy;
  logic             fetchModeQ;

  txpath_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .modeWrEn       (modeWrEn),
    .modeWrVal      (modeWrVal),
    .wideFmt        (wideFmt),
    .hostXferActive (hostXferActive),
    .coreWrEn       (coreWrEn),
    .hostRdEn       (hostRdEn),
    .strobes        (strobes),
    .coreTxReq      (coreTxReq),
    .hostRxReq      (hostRxReq),
    .occupancy      (occupancy),
    .fetchModeQ     (fetchModeQ)
  );

  txpath_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (coreWrData),
    .rdData  (hostRdData)
  );
endmodule

// File: rtl/core_host_txpath_checker.sv
module core_host_txpath_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              modeWrEn,
  input logic              modeWrVal,
  input logic              hostXferActive,
  input logic              coreWrEn,
  input logic              hostRdEn,
  input logic [DATA_W-1:0] hostRdData,
  input logic              coreTxReq,
  input logic              hostRxReq,
  input logic [CNT_W-1:0]  occupancy,
  input logic              fetchModeQ
);
  p_mode_write_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (modeWrEn && modeWrVal) |=> (!coreTxReq && !hostRxReq));

  p_fetch_write_takes_r3: assert property (@(posedge clk) disable iff (rst)
    (fetchModeQ && coreTxReq && coreWrEn && hostXferActive && !modeWrEn)
      |=> (!coreTxReq && hostRxReq));

  p_fetch_single_word_r4: assert property (@(posedge clk) disable iff (rst)
    fetchModeQ |-> (occupancy <= CNT_W'(1)));

  p_idle_discards_r5: assert property (@(posedge clk) disable iff (rst)
    (fetchModeQ && !hostXferActive && !modeWrEn) |=> (!coreTxReq && !hostRxReq));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    occupancy <= CNT_W'(DEPTH));

  p_empty_read_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (hostRdEn && !hostRxReq) |=> $stable(hostRdData));

  p_full_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (!fetchModeQ && !coreTxReq && coreWrEn && !hostRdEn && !modeWrEn)
      |=> $stable(occupancy));
endmodule

bind core_host_txpath core_host_txpath_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .modeWrEn       (modeWrEn),
  .modeWrVal      (modeWrVal),
  .hostXferActive (hostXferActive),
  .coreWrEn       (coreWrEn),
  .hostRdEn       (hostRdEn),
  .hostRdData     (hostRdData),
  .coreTxReq      (coreTxReq),
  .hostRxReq      (hostRxReq),
  .occupancy      (occupancy),
  .fetchModeQ     (fetchModeQ)
);

// File: tb/core_host_txpath_tb.sv
module core_host_txpath_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 6;
  localparam int NVEC   = 41;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              modeWrEn = 1'b0;
  logic              modeWrVal = 1'b0;
  logic              wideFmt = 1'b0;
  logic              hostXferActive = 1'b0;
  logic              coreWrEn = 1'b0;
  logic [DATA_W-1:0] coreWrData = '0;
  logic              hostRdEn = 1'b0;
  logic [DATA_W-1:0] hostRdData;
  logic              coreTxReq;
  logic              hostRxReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  core_host_txpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .modeWrEn(modeWrEn), .modeWrVal(modeWrVal),
    .wideFmt(wideFmt), .hostXferActive(hostXferActive), .coreWrEn(coreWrEn),
    .coreWrData(coreWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .coreTxReq(coreTxReq), .hostRxReq(hostRxReq)
  );

  // {mw, mv, xf, wd, wr, wdat[15:0], rd, expTx, expRx, expData[15:0], tag[7:0]}
  function automatic logic [47:0] v(input logic mw, mv, xf, wd, wr,
                                    input logic [15:0] wdat, input logic rd,
                                    input logic etx, erx, input logic [15:0] edat,
                                    input int tag);
    return {mw, mv, xf, wd, wr, wdat, rd, etx, erx, edat, 8'(tag)};
  endfunction

  localparam logic [47:0] VEC [NVEC] = '{
    v(0,0,0,0,0,16'h0000,0, 0,0,16'h0000, 1),   // R1 idle after reset
    v(0,0,1,0,0,16'h0000,0, 1,0,16'h0000, 3),   // R3 transfer opens
    v(0,0,1,0,1,16'h1111,0, 0,1,16'h0000, 3),   // R3 core supplies word
    v(0,0,1,0,1,16'h2222,0, 0,1,16'h0000, 4),   // R4 second word ignored
    v(0,0,1,0,0,16'h0000,1, 1,0,16'h1111, 7),   // R7 host takes word
    v(0,0,1,0,1,16'h3333,0, 0,1,16'h1111, 3),   // R3
    v(0,0,0,0,0,16'h0000,0, 0,0,16'h1111, 5),   // R5 idle discards
    v(0,0,0,0,1,16'h4444,0, 0,0,16'h1111, 5),   // R5 write while idle
    v(0,0,1,0,0,16'h0000,0, 1,0,16'h1111, 3),   // R3
    v(0,0,1,0,0,16'h0000,1, 1,0,16'h1111, 8),   // R8 empty read
    v(0,0,1,0,1,16'h5555,0, 0,1,16'h1111, 3),   // R3
    v(1,1,1,0,0,16'h0000,0, 0,0,16'h1111, 2),   // R2 mode write 1
    v(1,0,0,0,0,16'h0000,0, 1,0,16'h1111, 6),   // R6 enter pre-fetch
    v(0,0,0,0,1,16'hA000,0, 1,1,16'h1111, 6),   // R6
    v(0,0,0,0,1,16'hA001,0, 1,1,16'h1111, 6),
    v(0,0,0,0,1,16'hA002,0, 1,1,16'h1111, 6),
    v(0,0,0,0,1,16'hA003,0, 1,1,16'h1111, 6),
    v(0,0,0,0,1,16'hA004,0, 1,1,16'h1111, 6),
    v(0,0,0,0,1,16'hA005,0, 0,1,16'h1111, 6),   // R6 full at DEPTH
    v(0,0,0,0,1,16'hBEEF,0, 0,1,16'h1111, 9),   // R9 write at capacity
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hA000, 7),   // R7 oldest first
    v(0,0,0,0,1,16'hA006,1, 1,1,16'hA001,10),   // R10 simultaneous
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hA002, 7),
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hA003, 7),
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hA004, 7),
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hA005, 7),
    v(0,0,0,0,0,16'h0000,1, 1,0,16'hA006, 7),   // R7 pointer wrap
    v(0,0,0,0,0,16'h0000,1, 1,0,16'hA006, 8),   // R8
    v(0,0,0,0,1,16'hC000,1, 1,1,16'hA006,10),   // R10 on empty path
    v(0,0,0,0,0,16'h0000,1, 1,0,16'hC000, 7),
    v(0,0,0,1,0,16'h0000,0, 1,0,16'hC000, 6),   // R6 select wide
    v(0,0,0,1,1,16'hD000,0, 1,1,16'hC000, 6),
    v(0,0,0,1,1,16'hD001,0, 1,1,16'hC000, 6),
    v(0,0,0,1,1,16'hD002,0, 0,1,16'hC000, 6),   // R6 full at DEPTH/2
    v(0,0,0,0,1,16'hD003,0, 0,1,16'hC000,11),   // R11 late narrow ignored
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hD000,11),
    v(0,0,0,0,1,16'hD004,0, 0,1,16'hD000,11),   // R11 still three deep
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hD001, 7),
    v(0,0,0,0,0,16'h0000,1, 1,1,16'hD002, 7),
    v(0,0,0,0,0,16'h0000,1, 1,0,16'hD004, 7),
    v(0,0,0,0,0,16'h0000,0, 1,0,16'hD004, 6)
  };

  task automatic checkOut(input int tag, input logic etx, input logic erx,
                          input logic [DATA_W-1:0] edat);
    checks++;
    if (coreTxReq !== etx || hostRxReq !== erx || hostRdData !== edat) begin
      fails++;
      $display("FAIL R%0d: tx=%b rx=%b data=%h expected tx=%b rx=%b data=%h",
               tag, coreTxReq, hostRxReq, hostRdData, etx, erx, edat);
    end
  endtask

  task automatic drive(input logic mw, mv, xf, wd, wr, input logic [15:0] wdat,
                       input logic rd);
    @(negedge clk);
    modeWrEn = mw; modeWrVal = mv; hostXferActive = xf; wideFmt = wd;
    coreWrEn = wr; coreWrData = wdat; hostRdEn = rd;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checkOut(1, 1'b0, 1'b0, '0);               // R1 state straight out of reset

    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] cur;
      cur = VEC[i];
      drive(cur[47], cur[46], cur[45], cur[44], cur[43], cur[42:27], cur[26]);
      checkOut(int'(cur[7:0]), cur[25], cur[24], cur[23:8]);
    end

    // R1: reset in the middle of pre-fetch operation
    drive(0,0,0,0,1,16'h7777,0);
    checkOut(6, 1'b1, 1'b1, 16'hD004);
    @(negedge clk); rst = 1'b1; coreWrEn = 1'b0;
    @(posedge clk); #1;
    checkOut(1, 1'b0, 1'b0, 16'h0000);
    @(negedge clk); rst = 1'b0;

    // R2: mode write of 1 while pre-fetch FIFO holds data
    drive(1,0,0,0,0,16'h0000,0);
    drive(0,0,0,0,1,16'h8888,0);
    drive(0,0,0,0,1,16'h9999,0);
    checkOut(6, 1'b1, 1'b1, 16'h0000);
    drive(1,1,0,0,0,16'h0000,0);
    checkOut(2, 1'b0, 1'b0, 16'h0000);
    drive(0,0,1,0,0,16'h0000,1);               // R2 data is gone: empty read
    checkOut(2, 1'b1, 1'b0, 16'h0000);
    drive(0,0,0,0,0,16'h0000,0);

    finishRun();
  end
endmodule